// File: doc/BRIEF.md
# Tone-Signalling Packet Bit Encoder

This block turns one command (an 8-bit opcode, an 8-bit argument and a 16-bit unit identifier) into a complete single-packet signalling frame. It then serialises that frame one bit at a time for a downstream tone modulator. When a start strobe arrives while the block is idle, it captures the fields. In the same cycle it builds the whole frame in parallel logic:

- a seven-byte payload with a 16-bit CRC and a zero status byte;
- seven bytes of rate-1/2 convolutional parity over that payload;
- a bit interleaver over the resulting 14-byte codeword;
- a fixed lead-in of preamble and sync bytes in front of the codeword.

The 200-bit frame is held in a register. Each pulse of `bit_en` releases the next bit, most significant bit of each byte first. Every bit passes through an inverted differential coder before it leaves the block.

The modulator drives `bit_en` at its own bit rate. For each pulse it receives `tx_bit` together with a one-cycle `tx_valid` strobe. `done` marks the final bit of the frame. The encoder then becomes idle and accepts the next start. A start request that arrives during a frame is dropped.

Top module: `sig_pkt_encoder`

## Requirements
- R1: After reset, and after a reset that lands in the middle of a frame, `tx_valid`, `done` and `tx_bit` are 0 and the block is idle. Later `bit_en` pulses produce no `tx_valid` until a new start is accepted.
- R2: A `start` sampled while idle is accepted and captures the field inputs. A `bit_en` sampled in the accept cycle, or while idle, is ignored. While a frame is active, each sampled `bit_en` produces exactly one one-cycle `tx_valid` in the next cycle. A frame yields exactly 200 such strobes.
- R3: A `start` sampled while a frame is active, including in the cycle of its final `bit_en`, is ignored. The frame in flight is unchanged and no new frame begins.
- R4: Before differential coding, frame bits 0..87 are 40 zero bits, then 0xCC, then the sync bytes 0x07, 0x09, 0x2A, 0x44, 0x6F. Each byte is sent most significant bit first.
- R5: Codeword bytes 0..6 are, in this order: opcode, argument, unit-ID high byte, unit-ID low byte, CRC low byte, CRC high byte, status 0x00.
- R6: The CRC is computed over codeword bytes 0..3, taking each byte least significant bit first. It starts from 0, shifts right with polynomial 0x8408, and is XORed with 0xFFFF at the end.
- R7: Treat the 56 payload bits as a stream d[n], where n = 8*byte + bit. Parity stream p[n] = d[n]^d[n-2]^d[n-5]^d[n-6], with terms before the stream start taken as 0. Codeword byte 7+i bit b holds p[8i+b].
- R8: Codeword bit k (byte k/8, bit k%8) is placed at slot (k%7)*16 + k/7. Slot s becomes bit 7-(s%8) of coded byte s/8. The 14 coded bytes form frame bytes 11..24.
- R9: With a previous bit that is 0 at the start of each frame, `tx_bit` is 1 when the current frame bit equals the previous frame bit and 0 when it differs. The coding covers all 200 bits.
- R10: `done` pulses for one cycle, together with the `tx_valid` of the 200th bit. The block is idle in that cycle, so a `start` sampled in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to encode the presented fields |
| opcode | input | 8 | Command opcode |
| argument | input | 8 | Command argument |
| unit_id | input | 16 | Sender unit identifier |
| bit_en | input | 1 | Bit-rate enable from the modulator |
| tx_bit | output | 1 | Differentially coded frame bit |
| tx_valid | output | 1 | One-cycle strobe: new `tx_bit` |
| done | output | 1 | One-cycle strobe with the last frame bit |

## Verification
Two pairs of events can fall in the same cycle. The first is a start request and the final bit enable of a frame. The bench raises `start` with different fields on the exact cycle of the 200th `bit_en`. It judges the request dropped when later enables give no strobes and the delivered frame still decodes to the first command. The second is frame completion and a new acceptance. The bench raises `start` and `bit_en` together in the `done` cycle. It expects no extra strobe in the accept cycle, and it expects the next 200 bits to decode to the new fields.

// File: rtl/sig_pkt_pkg.sv
package sig_pkt_pkg;
  localparam int BYTE_W      = 8;
  localparam int PAY_BYTES   = 7;
  localparam int CRC_BYTES   = 4;
  localparam int CW_BYTES    = 2 * PAY_BYTES;
  localparam int PAY_BITS    = PAY_BYTES * BYTE_W;
  localparam int CW_BITS     = CW_BYTES * BYTE_W;
  localparam int ILV_STRIDE  = CW_BITS / PAY_BYTES;
  localparam int LEAD_BYTES  = 11;
  localparam int LEAD_BITS   = LEAD_BYTES * BYTE_W;
  localparam int FRAME_BITS  = LEAD_BITS + CW_BITS;
  localparam int CNT_W       = $clog2(FRAME_BITS + 1);

  // 40 zero bits, 0xCC, then five sync bytes; first bit at the MSB
  localparam logic [LEAD_BITS-1:0] LEAD_IN = 88'h0000000000_CC_07092A446F;

  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_XOROUT = 16'hFFFF;
  localparam logic [7:0]  STATUS_VAL = 8'h00;
endpackage

// File: rtl/sig_pkt_crc.sv
// Reflected CRC-16 over NBYTES bytes; byte j sits at msg[8j +: 8].
module sig_pkt_crc
  import sig_pkt_pkg::*;
#(
  parameter int NBYTES = CRC_BYTES
) (
  input  logic [NBYTES*BYTE_W-1:0] msg,
  output logic [15:0]              crc
);
  always_comb begin
    logic [15:0] acc;
    acc = '0;
    for (int j = 0; j < NBYTES; j++) begin
      acc = acc ^ {8'h00, msg[j*BYTE_W +: BYTE_W]};
      for (int b = 0; b < BYTE_W; b++) begin
        if (acc[0]) acc = (acc >> 1) ^ CRC_POLY;
        else        acc = acc >> 1;
      end
    end
    crc = acc ^ CRC_XOROUT;
  end
endmodule

// File: rtl/sig_pkt_fec.sv
// Convolutional parity p[n] = d[n]^d[n-2]^d[n-5]^d[n-6], zero history.
module sig_pkt_fec
  import sig_pkt_pkg::*;
#(
  parameter int NBITS = PAY_BITS
) (
  input  logic [NBITS-1:0] din,
  output logic [NBITS-1:0] par
);
  localparam int HIST = 6;
  logic [NBITS+HIST-1:0] padded;

  assign padded = {din, {HIST{1'b0}}};

  for (genvar n = 0; n < NBITS; n++) begin : g_tap
    assign par[n] = padded[n+HIST] ^ padded[n+HIST-2] ^
                    padded[n+HIST-5] ^ padded[n+HIST-6];
  end
endmodule

// File: rtl/sig_pkt_ilv.sv
// Pure-wiring interleaver: input bit k (LSB-first stream) goes to slot
// (k % ROWS) * STRIDE + k / ROWS; slot 0 is the output MSB.
module sig_pkt_ilv
  import sig_pkt_pkg::*;
#(
  parameter int NBITS  = CW_BITS,
  parameter int ROWS   = PAY_BYTES,
  parameter int STRIDE = ILV_STRIDE
) (
  input  logic [NBITS-1:0] cw_in,
  output logic [NBITS-1:0] cw_out
);
  for (genvar k = 0; k < NBITS; k++) begin : g_map
    localparam int SLOT = (k % ROWS) * STRIDE + (k / ROWS);
    assign cw_out[NBITS-1-SLOT] = cw_in[k];
  end
endmodule

// File: rtl/sig_pkt_ser.sv
// Frame holding register, bit counter and inverted differential coder.
module sig_pkt_ser
  import sig_pkt_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] frame_in,
  input  logic             bit_en,
  output logic             active,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             done
);
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [NBITS-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic             prev;
  logic             cur;

  assign cur = shreg[NBITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      prev     <= 1'b0;
      active   <= 1'b0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      done     <= 1'b0;
      if (!active) begin
        if (load) begin
          shreg  <= frame_in;
          cnt    <= '0;
          prev   <= 1'b0;
          active <= 1'b1;
        end
      end else if (bit_en) begin
        tx_bit   <= ~(cur ^ prev);
        prev     <= cur;
        shreg    <= shreg << 1;
        tx_valid <= 1'b1;
        cnt      <= cnt + 1'b1;
        if (cnt == LAST) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sig_pkt_encoder.sv
module sig_pkt_encoder
  import sig_pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  argument,
  input  logic [15:0] unit_id,
  input  logic        bit_en,
  output logic        tx_bit,
  output logic        tx_valid,
  output logic        done
);
  logic [CRC_BYTES*BYTE_W-1:0] crc_msg;
  logic [15:0]                 crc;
  logic [PAY_BITS-1:0]         pay_bits;
  logic [PAY_BITS-1:0]         par_bits;
  logic [CW_BITS-1:0]          cw_bits;
  logic [CW_BITS-1:0]          ilv_bits;
  logic [FRAME_BITS-1:0]       frame;
  logic                        busy;

  // byte 0 in the least significant position
  assign crc_msg  = {unit_id[7:0], unit_id[15:8], argument, opcode};
  assign pay_bits = {STATUS_VAL, crc[15:8], crc[7:0], crc_msg};
  assign cw_bits  = {par_bits, pay_bits};
  assign frame    = {LEAD_IN, ilv_bits};

  sig_pkt_crc #(.NBYTES(CRC_BYTES)) u_crc (
    .msg (crc_msg),
    .crc (crc)
  );

  sig_pkt_fec #(.NBITS(PAY_BITS)) u_fec (
    .din (pay_bits),
    .par (par_bits)
  );

  sig_pkt_ilv #(.NBITS(CW_BITS), .ROWS(PAY_BYTES), .STRIDE(ILV_STRIDE)) u_ilv (
    .cw_in  (cw_bits),
    .cw_out (ilv_bits)
  );

  sig_pkt_ser #(.NBITS(FRAME_BITS)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .frame_in (frame),
    .bit_en   (bit_en),
    .active   (busy),
    .tx_bit   (tx_bit),
    .tx_valid (tx_valid),
    .done     (done)
  );
endmodule

// File: rtl/sig_pkt_encoder_chk.sv
module sig_pkt_encoder_chk
  import sig_pkt_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic start,
  input logic bit_en,
  input logic busy,
  input logic tx_bit,
  input logic tx_valid,
  input logic done
);
  logic [CNT_W-1:0] nv;

  always_ff @(posedge clk) begin
    if (rst)                 nv <= '0;
    else if (start && !busy) nv <= '0;
    else if (tx_valid)       nv <= nv + 1'b1;
  end

  // R2: every strobe answers an enable sampled while active
  a_r2_valid_from_en: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ($past(bit_en) && $past(busy)));

  // R2: a frame only begins from an accepted start
  a_r2_begin_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R3: without an enable an active frame never ends, whatever start does
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_en) |=> busy);

  // R10: done comes with the 200th strobe and leaves the block idle
  a_r10_done_last: assert property (@(posedge clk) disable iff (rst)
    done |-> (tx_valid && !busy && nv == CNT_W'(FRAME_BITS - 1)));

  // R9: 40 zero lead-in bits with a zero start code as all ones
  a_r9_lead_ones: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && nv < CNT_W'(40)) |-> tx_bit);
endmodule

bind sig_pkt_encoder sig_pkt_encoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .bit_en   (bit_en),
  .busy     (busy),
  .tx_bit   (tx_bit),
  .tx_valid (tx_valid),
  .done     (done)
);

// File: tb/test_sig_pkt_encoder.sv
`timescale 1ns/1ps
module test_sig_pkt_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  argument = '0;
  logic [15:0] unit_id = '0;
  logic        bit_en = 1'b0;
  logic        tx_bit, tx_valid, done;

  always #2 clk = ~clk;  // 250 MHz

  sig_pkt_encoder i_sig_pkt_encoder (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .argument(argument),
    .unit_id(unit_id), .bit_en(bit_en), .tx_bit(tx_bit), .tx_valid(tx_valid),
    .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int rx_n = 0;
  int done_n = 0;
  int done_at = -1;
  logic rx_bits [256];

  logic [7:0] m_cw [14];
  logic [7:0] m_fr [25];
  logic       m_tx [200];

  // stimulus: {gap, opcode, argument, unit_id}
  localparam logic [33:0] VEC [5] = '{
    {2'd0, 8'h01, 8'h80, 16'h1234},
    {2'd1, 8'h12, 8'h34, 16'h5678},
    {2'd3, 8'hFF, 8'hFF, 16'hFFFF},
    {2'd0, 8'h00, 8'h00, 16'h0000},
    {2'd2, 8'hA5, 8'h5A, 16'hC33C}
  };

  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (rx_n < 256) rx_bits[rx_n] = tx_bit;
      if (done) done_at = rx_n;
      rx_n++;
    end
    if (!rst && done) done_n++;
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary_and_end();
  end

  task automatic chk(input string tag, input logic [199:0] act, input logic [199:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_crc(input logic [7:0] b0, b1, b2, b3);
    logic [15:0] c = 16'h0000;
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    for (int i = 0; i < 4; i++) begin
      c = c ^ {8'h00, bs[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c ^ 16'hFFFF;
  endfunction

  task automatic build(input logic [7:0] op, ag, input logic [15:0] uid);
    logic [15:0] c;
    logic [7:0] sr = 8'h00;
    logic sl [112];
    int k = 0;
    logic prev = 1'b0;
    logic [87:0] lead = 88'h0000000000CC07092A446F;
    c = m_crc(op, ag, uid[15:8], uid[7:0]);
    m_cw[0] = op; m_cw[1] = ag; m_cw[2] = uid[15:8]; m_cw[3] = uid[7:0];
    m_cw[4] = c[7:0]; m_cw[5] = c[15:8]; m_cw[6] = 8'h00;
    for (int i = 0; i < 7; i++) begin
      logic [7:0] bo = 8'h00;
      for (int b = 0; b < 8; b++) begin
        sr = {sr[6:0], m_cw[i][b]};
        bo[b] = sr[6] ^ sr[5] ^ sr[2] ^ sr[0];
      end
      m_cw[7+i] = bo;
    end
    for (int i = 0; i < 14; i++)
      for (int b = 0; b < 8; b++) begin
        sl[k] = m_cw[i][b];
        k += 16;
        if (k >= 112) k -= 111;
      end
    for (int i = 0; i < 11; i++) m_fr[i] = lead[87-8*i -: 8];
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 8; j++) m_fr[11+i][7-j] = sl[8*i+j];
    for (int n = 0; n < 200; n++) begin
      logic cur = m_fr[n/8][7-(n%8)];
      m_tx[n] = (cur == prev);
      prev = cur;
    end
  endtask

  task automatic verify(input logic [7:0] op, ag, input logic [15:0] uid);
    logic [7:0] rfr [25];
    logic [7:0] rcw [14];
    logic rawp = 1'b0;
    logic [87:0] lead_act = '0;
    logic [111:0] cod_act = '0, cod_exp = '0;
    logic [55:0] par_act = '0, par_exp = '0;
    logic [199:0] tx_act = '0, tx_exp = '0;
    build(op, ag, uid);
    chk("R2 strobes per frame", 200'(rx_n), 200'd200);
    chk("R10 done pulse count", 200'(done_n), 200'd1);
    chk("R10 done on bit 200", 200'(done_at), 200'd199);
    for (int n = 0; n < 200; n++) begin
      logic raw = rx_bits[n] ? rawp : ~rawp;
      rfr[n/8][7-(n%8)] = raw;
      rawp = raw;
      tx_act = {tx_act[198:0], rx_bits[n]};
      tx_exp = {tx_exp[198:0], m_tx[n]};
    end
    for (int i = 0; i < 11; i++) lead_act = {lead_act[79:0], rfr[i]};
    chk("R4 lead-in and sync", 200'(lead_act), 200'(88'h0000000000CC07092A446F));
    for (int i = 11; i < 25; i++) begin
      cod_act = {cod_act[103:0], rfr[i]};
      cod_exp = {cod_exp[103:0], m_fr[i]};
    end
    chk("R8 interleaved codeword", 200'(cod_act), 200'(cod_exp));
    for (int k = 0; k < 112; k++) begin
      int s = (k % 7) * 16 + k / 7;
      rcw[k/8][k%8] = rfr[11 + s/8][7 - (s%8)];
    end
    chk("R5 payload fields", 200'({rcw[0], rcw[1], rcw[2], rcw[3], rcw[6]}),
        200'({op, ag, uid, 8'h00}));
    chk("R6 crc", 200'({rcw[5], rcw[4]}), 200'(m_crc(op, ag, uid[15:8], uid[7:0])));
    for (int i = 7; i < 14; i++) begin
      par_act = {par_act[47:0], rcw[i]};
      par_exp = {par_exp[47:0], m_cw[i]};
    end
    chk("R7 parity bytes", 200'(par_act), 200'(par_exp));
    chk("R9 differential bits", tx_act, tx_exp);
  endtask

  task automatic rx_clear();
    rx_n = 0; done_n = 0; done_at = -1;
  endtask

  task automatic start_frame(input logic [7:0] op, ag, input logic [15:0] uid);
    opcode = op; argument = ag; unit_id = uid; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic pulse_bits(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bit_en = 1'b1;
      @(posedge clk); #1;
      bit_en = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", 200'({tx_valid, done, tx_bit}), 200'd0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R2: enables while idle are ignored
    rx_clear();
    pulse_bits(3, 0);
    repeat (2) begin @(posedge clk); #1; end
    chk("R2 idle enable ignored", 200'(rx_n), 200'd0);

    // table walk
    for (int v = 0; v < 5; v++) begin
      rx_clear();
      start_frame(VEC[v][31:24], VEC[v][23:16], VEC[v][15:0]);
      pulse_bits(200, int'(VEC[v][33:32]));
      repeat (2) begin @(posedge clk); #1; end
      verify(VEC[v][31:24], VEC[v][23:16], VEC[v][15:0]);
    end

    // R3: start mid-frame and on the final enable are ignored
    rx_clear();
    start_frame(8'h3C, 8'h76, 16'hBEEF);
    pulse_bits(50, 0);
    opcode = 8'h99; argument = 8'h11; unit_id = 16'h0F0F;
    start = 1'b1; bit_en = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; bit_en = 1'b0;
    pulse_bits(148, 1);
    opcode = 8'h44; argument = 8'h22; unit_id = 16'hA0A0;
    start = 1'b1; bit_en = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; bit_en = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
    pulse_bits(4, 0);
    repeat (2) begin @(posedge clk); #1; end
    chk("R3 no restart after busy start", 200'(rx_n), 200'd200);
    verify(8'h3C, 8'h76, 16'hBEEF);

    // R10: start in the done cycle is accepted; enable there is ignored
    rx_clear();
    start_frame(8'h5A, 8'hC3, 16'h0001);
    pulse_bits(199, 0);
    bit_en = 1'b1;
    @(posedge clk); #1;
    opcode = 8'h81; argument = 8'h7E; unit_id = 16'h8000;
    start = 1'b1; bit_en = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; bit_en = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    chk("R10 no strobe in accept cycle", 200'(rx_n), 200'd200);
    verify(8'h5A, 8'hC3, 16'h0001);
    rx_clear();
    pulse_bits(200, 0);
    repeat (2) begin @(posedge clk); #1; end
    verify(8'h81, 8'h7E, 16'h8000);

    // R1: reset in mid-frame returns to idle
    rx_clear();
    start_frame(8'h10, 8'h20, 16'h3040);
    pulse_bits(30, 0);
    rst = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset outputs", 200'({tx_valid, done, tx_bit}), 200'd0);
    @(posedge clk); #1;
    rx_clear();
    pulse_bits(5, 0);
    repeat (2) begin @(posedge clk); #1; end
    chk("R1 idle after reset", 200'(rx_n), 200'd0);

    summary_and_end();
  end
endmodule